// File: doc/BRIEF.md
# Call/Return Control Sequencer with Memory-Resident Return Stack

This block is the hardwired control unit and register datapath for a 32-bit processor built around three internal buses. Two source buses feed an ALU, and a third bus carries the result to a destination register. The block implements two instructions. The first is a subroutine call whose target address is formed by adding an index register to the instruction's address field and then reading a pointer word from memory at that sum. The second is a return that takes the address back off a stack held in main memory.

Every instruction steps through up to three major phases: fetch, defer and execute. Each phase has four minor cycles. In each minor cycle the sequencer picks the source of each bus, the ALU function and the destination register. It also raises the memory read and write strobes.

The stack lives in the external word-addressed memory and grows toward higher addresses. A call stores the return address at the current stack pointer and then increments the pointer. A return decrements the pointer first and then reads. Memory reads carry one wait cycle: the word addressed in a read cycle is captured in the cycle that follows.

Top module: `callret_core`

## Requirements
- R1: While reset is held and right after it, the sequencer is in fetch (phase code 0), minor cycle 0. PC equals the `RESET_PC` parameter, SP equals `STACK_BASE`, and no write is driven.
- R2: Each instruction starts with a read at the PC address in fetch minor cycle 0, and PC then advances by one. The instruction word is taken from the read data one cycle later.
- R3: The opcode is instruction bits [31:27]. Call is 01110 and takes 12 cycles (fetch, defer with phase code 1, execute with phase code 2). Return is 01010 and takes 8 cycles (fetch, then execute with no defer). Any other opcode takes 4 cycles, makes no memory access after its fetch read, and leads straight to the next fetch.
- R4: For a call, the effective address is bits [23:0] plus index register n, where n is bits [26:24]. Register 0 is always zero and register n holds n×`REG_STEP`. The defer phase reads memory at this address in its minor cycle 0.
- R5: After a call, PC equals the word read at the effective address (indirect target). PC does not change during defer.
- R6: A call writes the address of the word after the call instruction to memory at the current SP in execute minor cycle 2. SP increments by one in execute minor cycle 3.
- R7: A return decrements SP in execute minor cycle 0 and reads memory at the new SP in minor cycle 1. PC then takes the word read.
- R8: Nested calls return in last-in, first-out order. An inner return address sits one word above the outer one, and a return restores SP to its value before the matching call.
- R9: Read data is sampled only in the cycle after the read strobe. Data presented in the strobe cycle itself is not used.
- R10: The write strobe is asserted only in execute minor cycle 2, and never together with the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 32 | Memory read data, valid in the cycle after `mem_rd` |
| mem_addr | output | 16 | Memory address for the current cycle's strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| phase_o | output | 2 | Major phase: 0 fetch, 1 defer, 2 execute |
| tick_o | output | 2 | Minor cycle 0 to 3 |

## Verification
The hardest case to reach is a return whose address was written by an earlier call. This only happens once the memory model has absorbed that call's write, and it is what shows the stack is really last-in, first-out. The stimulus is a small program in the bench's memory. The first call goes through register 0 and the second through register 2, which nests them, and the two returns then unwind them. A third call through register 7 reuses the freed stack slot. The bench drives read data only in the cycle after each strobe and drives a poison value in every other cycle, so capturing data a cycle early changes the program's path.

// File: rtl/callret_pkg.sv
package callret_pkg;

    localparam int OPC_W = 5;
    localparam int IDX_W = 3;

    localparam logic [OPC_W-1:0] OP_CALL = 5'b01110;
    localparam logic [OPC_W-1:0] OP_RETN = 5'b01010;

    typedef enum logic [1:0] {
        PH_F = 2'd0,
        PH_D = 2'd1,
        PH_E = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        S1_NONE,
        S1_PC,
        S1_SP,
        S1_MAR,
        S1_IRA
    } src1_e;

    typedef enum logic [2:0] {
        S2_NONE,
        S2_ONE,
        S2_NEG1,
        S2_MBR,
        S2_IDX
    } src2_e;

    typedef enum logic [1:0] {
        FN_PASS1,
        FN_PASS2,
        FN_ADD
    } alu_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_PC,
        DST_SP,
        DST_MAR,
        DST_MBR,
        DST_IR
    } dst_e;

    typedef struct packed {
        src1_e s1;
        src2_e s2;
        alu_e  fn;
        dst_e  dst;
        logic  rd;
        logic  wr;
    } uop_t;

    function automatic uop_t mk_uop(src1_e s1, src2_e s2, alu_e fn, dst_e dst,
                                    logic rd, logic wr);
        uop_t u;
        u.s1  = s1;
        u.s2  = s2;
        u.fn  = fn;
        u.dst = dst;
        u.rd  = rd;
        u.wr  = wr;
        return u;
    endfunction

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
    import callret_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output phase_e           phase,
    output logic [1:0]       tick,
    output uop_t             uop
);

    typedef struct packed {
        phase_e     ph;
        logic [1:0] tk;
    } seq_t;

    seq_t seq_d, seq_q;
    logic is_call, is_retn;

    assign is_call = (opcode == OP_CALL);
    assign is_retn = (opcode == OP_RETN);

    always_comb begin
        seq_d = seq_q;
        uop   = mk_uop(S1_NONE, S2_NONE, FN_PASS1, DST_NONE, 1'b0, 1'b0);

        unique case (seq_q.ph)
            PH_F: begin
                unique case (seq_q.tk)
                    2'd0: uop = mk_uop(S1_PC, S2_NONE, FN_PASS1, DST_MAR, 1'b1, 1'b0);
                    2'd1: uop = mk_uop(S1_PC, S2_ONE, FN_ADD, DST_PC, 1'b0, 1'b0);
                    2'd2: uop = mk_uop(S1_NONE, S2_MBR, FN_PASS2, DST_IR, 1'b0, 1'b0);
                    default: begin
                        if (is_call) begin
                            uop = mk_uop(S1_IRA, S2_IDX, FN_ADD, DST_MAR, 1'b0, 1'b0);
                        end
                    end
                endcase
            end
            PH_D: begin
                unique case (seq_q.tk)
                    2'd0: uop = mk_uop(S1_NONE, S2_NONE, FN_PASS1, DST_NONE, 1'b1, 1'b0);
                    2'd2: uop = mk_uop(S1_NONE, S2_MBR, FN_PASS2, DST_MAR, 1'b0, 1'b0);
                    default: ;
                endcase
            end
            PH_E: begin
                if (is_call) begin
                    unique case (seq_q.tk)
                        2'd0: uop = mk_uop(S1_PC, S2_NONE, FN_PASS1, DST_MBR, 1'b0, 1'b0);
                        2'd1: uop = mk_uop(S1_MAR, S2_NONE, FN_PASS1, DST_PC, 1'b0, 1'b0);
                        2'd2: uop = mk_uop(S1_SP, S2_NONE, FN_PASS1, DST_MAR, 1'b0, 1'b1);
                        default: uop = mk_uop(S1_SP, S2_ONE, FN_ADD, DST_SP, 1'b0, 1'b0);
                    endcase
                end else if (is_retn) begin
                    unique case (seq_q.tk)
                        2'd0: uop = mk_uop(S1_SP, S2_NEG1, FN_ADD, DST_SP, 1'b0, 1'b0);
                        2'd1: uop = mk_uop(S1_SP, S2_NONE, FN_PASS1, DST_MAR, 1'b1, 1'b0);
                        2'd3: uop = mk_uop(S1_NONE, S2_MBR, FN_PASS2, DST_PC, 1'b0, 1'b0);
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase

        seq_d.tk = seq_q.tk + 2'd1;
        if (seq_q.tk == 2'd3) begin
            unique case (seq_q.ph)
                PH_F: begin
                    if (is_call) begin
                        seq_d.ph = PH_D;
                    end else if (is_retn) begin
                        seq_d.ph = PH_E;
                    end else begin
                        seq_d.ph = PH_F;
                    end
                end
                PH_D:    seq_d.ph = PH_E;
                default: seq_d.ph = PH_F;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_F, tk: 2'd0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.ph;
    assign tick  = seq_q.tk;

endmodule

// File: rtl/callret_idxregs.sv
module callret_idxregs #(
    parameter int DW       = 32,
    parameter int IDX_W    = 3,
    parameter int REG_STEP = 4
) (
    input  logic [IDX_W-1:0] sel,
    output logic [DW-1:0]    val
);

    localparam int NREG = 1 << IDX_W;

    logic [DW-1:0] bank [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            if (i == 0) begin : g_zero
                assign bank[i] = '0;
            end else begin : g_step
                assign bank[i] = DW'(i * REG_STEP);
            end
        end
    endgenerate

    assign val = bank[sel];

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
    import callret_pkg::*;
#(
    parameter int             DW         = 32,
    parameter int             AW         = 16,
    parameter logic [AW-1:0]  RESET_PC   = 16'h0010,
    parameter logic [AW-1:0]  STACK_BASE = 16'h0080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  uop_t             uop,
    input  logic [DW-1:0]    idx_val,
    input  logic [DW-1:0]    mem_rdata,
    output logic [OPC_W-1:0] opcode,
    output logic [IDX_W-1:0] idx_sel,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [AW-1:0]    pc,
    output logic [AW-1:0]    sp
);

    localparam int FLD_W = DW - OPC_W - IDX_W;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic          rd_wait;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [DW-1:0] bus1, bus2, bus3;

    always_comb begin
        unique case (uop.s1)
            S1_PC:   bus1 = DW'(dp_q.pc);
            S1_SP:   bus1 = DW'(dp_q.sp);
            S1_MAR:  bus1 = DW'(dp_q.mar);
            S1_IRA:  bus1 = DW'(dp_q.ir[FLD_W-1:0]);
            default: bus1 = '0;
        endcase

        unique case (uop.s2)
            S2_ONE:  bus2 = DW'(1);
            S2_NEG1: bus2 = '1;
            S2_MBR:  bus2 = dp_q.mbr;
            S2_IDX:  bus2 = idx_val;
            default: bus2 = '0;
        endcase

        unique case (uop.fn)
            FN_PASS2: bus3 = bus2;
            FN_ADD:   bus3 = bus1 + bus2;
            default:  bus3 = bus1;
        endcase
    end

    always_comb begin
        dp_d         = dp_q;
        dp_d.rd_wait = uop.rd;
        if (dp_q.rd_wait) begin
            dp_d.mbr = mem_rdata;
        end
        unique case (uop.dst)
            DST_PC:  dp_d.pc  = bus3[AW-1:0];
            DST_SP:  dp_d.sp  = bus3[AW-1:0];
            DST_MAR: dp_d.mar = bus3[AW-1:0];
            DST_MBR: dp_d.mbr = bus3;
            DST_IR:  dp_d.ir  = bus3;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q.pc      <= RESET_PC;
            dp_q.sp      <= STACK_BASE;
            dp_q.mar     <= '0;
            dp_q.mbr     <= '0;
            dp_q.ir      <= '0;
            dp_q.rd_wait <= 1'b0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign opcode    = dp_q.ir[DW-1 -: OPC_W];
    assign idx_sel   = dp_q.ir[DW-OPC_W-1 -: IDX_W];
    assign mem_addr  = dp_d.mar;
    assign mem_wdata = dp_q.mbr;
    assign pc        = dp_q.pc;
    assign sp        = dp_q.sp;

endmodule

// File: rtl/callret_core.sv
module callret_core
    import callret_pkg::*;
#(
    parameter int             DW         = 32,
    parameter int             AW         = 16,
    parameter logic [AW-1:0]  RESET_PC   = 16'h0010,
    parameter logic [AW-1:0]  STACK_BASE = 16'h0080,
    parameter int             REG_STEP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] sp_o,
    output logic [1:0]    phase_o,
    output logic [1:0]    tick_o
);

    uop_t             uop;
    phase_e           phase;
    logic [1:0]       tick;
    logic [OPC_W-1:0] opcode;
    logic [IDX_W-1:0] idx_sel;
    logic [DW-1:0]    idx_val;

    callret_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .phase  (phase),
        .tick   (tick),
        .uop    (uop)
    );

    callret_idxregs #(
        .DW       (DW),
        .IDX_W    (IDX_W),
        .REG_STEP (REG_STEP)
    ) u_idx (
        .sel (idx_sel),
        .val (idx_val)
    );

    callret_dpath #(
        .DW         (DW),
        .AW         (AW),
        .RESET_PC   (RESET_PC),
        .STACK_BASE (STACK_BASE)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .uop       (uop),
        .idx_val   (idx_val),
        .mem_rdata (mem_rdata),
        .opcode    (opcode),
        .idx_sel   (idx_sel),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc        (pc_o),
        .sp        (sp_o)
    );

    assign mem_rd  = uop.rd;
    assign mem_wr  = uop.wr;
    assign phase_o = phase;
    assign tick_o  = tick;

endmodule

// File: rtl/callret_core_chk.sv
module callret_core_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] sp_o,
    input logic [1:0]    phase_o,
    input logic [1:0]    tick_o
);

    // R10
    wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (phase_o == 2'd2 && tick_o == 2'd2));

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && tick_o == 2'd0) |-> (mem_rd && mem_addr == pc_o));

    // R6
    push_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && tick_o == 2'd3 && $past(mem_wr))
            |=> (sp_o == AW'($past(sp_o) + 1'b1)));

    // R7
    pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && tick_o == 2'd1 && mem_rd) |-> (mem_addr == sp_o));

    // R5
    defer_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1) |=> $stable(pc_o));

endmodule

bind callret_core callret_core_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .pc_o     (pc_o),
    .sp_o     (sp_o),
    .phase_o  (phase_o),
    .tick_o   (tick_o)
);

// File: tb/callret_core_bench.sv
module callret_core_bench;

    localparam int           DW    = 32;
    localparam int           AW    = 16;
    localparam logic [15:0]  RPC   = 16'h0010;
    localparam logic [15:0]  SBASE = 16'h0080;
    localparam int           STEP  = 4;
    localparam logic [31:0]  POISON = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] pc_o;
    logic [AW-1:0] sp_o;
    logic [1:0]    phase_o;
    logic [1:0]    tick_o;

    always #2 clk = ~clk;

    callret_core #(
        .DW(DW), .AW(AW), .RESET_PC(RPC), .STACK_BASE(SBASE), .REG_STEP(STEP)
    ) u_callret_core (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .pc_o(pc_o), .sp_o(sp_o), .phase_o(phase_o), .tick_o(tick_o)
    );

    typedef enum int {K_BOUND, K_RD, K_WR} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] addr;
        logic [31:0] data;
        logic [15:0] sp;
        int          cyc;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] mem [256];
    logic [15:0] shadow [16];
    int          depth;
    logic [15:0] e_pc, e_sp;
    int          e_cyc;
    int          checks = 0;
    int          errors = 0;
    int          cyc;
    logic        pend;
    logic [15:0] paddr;

    function automatic logic [31:0] enc(logic [4:0] op, logic [2:0] idx, logic [23:0] a);
        return {op, idx, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_item(input kind_e k, input logic [15:0] a, input logic [31:0] d,
                             input string tag);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.sp = e_sp; it.cyc = e_cyc; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drv_call(input logic [2:0] idx, input logic [15:0] a, input string tag);
        logic [15:0] eff;
        push_item(K_BOUND, e_pc, 0, tag);
        push_item(K_RD, e_pc, 0, "R2 fetch address");
        eff = a + 16'(idx * STEP);
        push_item(K_RD, eff, 0, "R4 defer address");
        push_item(K_WR, e_sp, 32'(e_pc + 16'd1), "R6 push");
        shadow[depth] = e_pc + 16'd1;
        depth++;
        e_sp  = e_sp + 16'd1;
        e_pc  = mem[eff[7:0]][15:0];
        e_cyc = e_cyc + 12;
    endtask

    task automatic drv_ret(input string tag);
        push_item(K_BOUND, e_pc, 0, tag);
        push_item(K_RD, e_pc, 0, "R2 fetch address");
        push_item(K_RD, e_sp - 16'd1, 0, "R7 pop address");
        depth--;
        e_sp  = e_sp - 16'd1;
        e_pc  = shadow[depth];
        e_cyc = e_cyc + 8;
    endtask

    task automatic drv_other(input string tag);
        push_item(K_BOUND, e_pc, 0, tag);
        push_item(K_RD, e_pc, 0, "R2 fetch address");
        e_pc  = e_pc + 16'd1;
        e_cyc = e_cyc + 4;
    endtask

    task automatic pop_expect(input kind_e k, output item_t it, output bit ok);
        if (sb.size() == 0) begin
            chk(1'b0, "R10 unexpected bus activity", 32'(k), 32'hFFFF);
            ok = 1'b0;
        end else begin
            it = sb.pop_front();
            ok = (it.kind == k);
            if (!ok) chk(1'b0, {it.tag, " transaction kind"}, 32'(k), 32'(it.kind));
        end
    endtask

    initial begin
        item_t it;
        bit    ok;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = enc(5'b01110, 3'd0, 24'h40);
        mem[8'h11] = enc(5'b01110, 3'd7, 24'h48);
        mem[8'h12] = enc(5'b11111, 3'd5, 24'h33);
        mem[8'h20] = enc(5'b01110, 3'd2, 24'h3C);
        mem[8'h21] = enc(5'b01010, 3'd0, 24'h00);
        mem[8'h30] = enc(5'b00000, 3'd1, 24'h77);
        mem[8'h31] = enc(5'b01010, 3'd0, 24'h00);
        mem[8'h50] = enc(5'b01010, 3'd3, 24'h05);
        mem[8'h40] = 32'h0000_0020;
        mem[8'h44] = 32'h0000_0030;
        mem[8'h64] = 32'h0000_0050;

        e_pc = RPC; e_sp = SBASE; e_cyc = 0; depth = 0;
        drv_call(3'd0, 16'h40, "R1 R3 reset start of first call");
        drv_call(3'd2, 16'h3C, "R5 R3 nested call target");
        drv_other("R5 R3 R8 inner target reached");
        drv_ret("R3 other opcode 4 cycles");
        drv_ret("R7 R8 R9 inner return");
        drv_call(3'd7, 16'h48, "R7 R8 R9 outer return");
        drv_ret("R4 R5 R6 call via register 7");
        drv_other("R7 R8 return after reused slot");
        push_item(K_BOUND, e_pc, 0, "R3 other opcode 31 path");

        rst_n = 1'b0;
        mem_rdata = POISON;
        pend = 1'b0;
        repeat (3) @(negedge clk);
        chk(phase_o == 2'd0 && tick_o == 2'd0, "R1 reset phase", {28'd0, phase_o, tick_o}, 0);
        chk(pc_o == RPC, "R1 reset PC", 32'(pc_o), 32'(RPC));
        chk(sp_o == SBASE, "R1 reset SP", 32'(sp_o), 32'(SBASE));
        chk(!mem_wr, "R1 no write in reset", 32'(mem_wr), 0);
        rst_n = 1'b1;
        cyc = 0;
        forever begin
            mem_rdata = pend ? mem[paddr[7:0]] : POISON;
            pend = 1'b0;
            if (phase_o == 2'd0 && tick_o == 2'd0) begin
                pop_expect(K_BOUND, it, ok);
                if (ok) begin
                    chk(pc_o == it.addr, {it.tag, " PC"}, 32'(pc_o), 32'(it.addr));
                    chk(sp_o == it.sp, {it.tag, " SP"}, 32'(sp_o), 32'(it.sp));
                    chk(cyc == it.cyc, {it.tag, " cycle count"}, 32'(cyc), 32'(it.cyc));
                end
                if (sb.size() == 0) break;
            end
            if (mem_rd) begin
                pop_expect(K_RD, it, ok);
                if (ok) chk(mem_addr == it.addr, it.tag, 32'(mem_addr), 32'(it.addr));
                pend = 1'b1;
                paddr = mem_addr;
            end
            if (mem_wr) begin
                pop_expect(K_WR, it, ok);
                if (ok) begin
                    chk(mem_addr == it.addr, {it.tag, " address"}, 32'(mem_addr), 32'(it.addr));
                    chk(mem_wdata == it.data, {it.tag, " data"}, mem_wdata, it.data);
                    chk(phase_o == 2'd2 && tick_o == 2'd2, "R10 write slot",
                        {28'd0, phase_o, tick_o}, 32'h0000_000A);
                end
                mem[mem_addr[7:0]] = mem_wdata;
            end
            if (cyc > 2000) begin
                chk(1'b0, "watchdog expired", 32'(cyc), 2000);
                break;
            end
            @(negedge clk);
            cyc++;
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule